// File: doc/BRIEF.md
# Prescaled Interrupt Counter with Selectable Event Source

This block produces a level interrupt for a cartridge-side memory controller. A CPU writes eight byte-wide registers that sit in a small window, and one of four event strobes is selected as the count source: a CPU bus cycle, a rising edge on the picture unit's A12 address line, a picture unit read, or a CPU write. Each selected event steps an 8-bit prescaler up or down. When the prescaler reaches its rollover point under a width mask, it steps an 8-bit main counter in the same direction.

The main counter can wrap in the active direction: from 0xFF to 0x00 when counting up, or from 0x00 to 0xFF when counting down. If the enable is set when this happens, the interrupt is latched and held until software acknowledges it. Values written to the prescaler and counter are first XORed with a stored key. A mirror register for a prescaler-size adjustment is kept and can be read back, but it does not change how counting works. A read port with its own address returns the register contents, so software can inspect the counter state.

Top module: `irq_prescale_counter`

## Requirements
- R1: A synchronous active-low reset clears the enable, the pending interrupt, the prescaler, the counter, the XOR key, the mode and the adjust register. After reset, irq is 0 and every read index returns 0.
- R2: Mode bits [1:0] select the counted strobe: 0 selects ev_cpu_cycle, 1 selects ev_a12_rise, 2 selects ev_ppu_read and 3 selects ev_cpu_write. The unselected strobes have no effect.
- R3: Mode bits [7:6] set the direction: 01 counts up and 10 counts down. With 00 or 11, events leave the prescaler and the counter unchanged.
- R4: When mode bit 2 is 1, the prescaler comparison uses only its low 3 bits (mask 0x07). When mode bit 2 is 0, it uses all 8 bits (mask 0xFF).
- R5: Counting up, each selected event adds 1 to the prescaler. If the masked new prescaler is 0, the counter adds 1. A new counter value of 0x00 is a wrap.
- R6: Counting down, each selected event subtracts 1 from the prescaler. If the masked new prescaler equals the mask, the counter subtracts 1. A new counter value of 0xFF is a wrap.
- R7: A write to index 6 stores the XOR key. A write to index 4 loads the prescaler with data XOR key. A write to index 5 loads the counter with data XOR key.
- R8: A write to index 0 sets the enable to data bit 0, and a 0 in that bit also clears the pending interrupt. A write to index 2 clears both the enable and the pending interrupt. A write to index 3 sets the enable.
- R9: A wrap sets irq on the next clock only if the enable was 1 before that edge. Once set, irq stays 1 until the acknowledge described in R8.
- R10: A write to index 7 stores the adjust byte, which reads back unchanged. Mode bit 3 and the adjust byte do not change the counting.
- R11: The read port returns the following by rd_addr: 0 gives the enable in bit 0, 1 the mode, 2 the pending flag in bit 0, 3 zero, 4 the prescaler, 5 the counter, 6 the key and 7 the adjust byte.
- R12: A load in the same cycle as a selected event takes priority for the register it loads. A counter load also suppresses the wrap in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index of the write |
| wr_data | input | 8 | Write data |
| ev_cpu_cycle | input | 1 | One-cycle pulse per CPU bus cycle |
| ev_a12_rise | input | 1 | One-cycle pulse per A12 rising edge |
| ev_ppu_read | input | 1 | One-cycle pulse per picture unit read |
| ev_cpu_write | input | 1 | One-cycle pulse per CPU write |
| rd_addr | input | 3 | Read index |
| rd_data | output | 8 | Register contents at rd_addr |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted prescaler or counter shows up on the read port on the clock right after the event that caused it. The bench sweeps rd_addr every cycle, so any one register is exposed within eight cycles. A wrong step decision or mask surfaces as a counter value that disagrees with the behavioural model, well before the delayed or missing irq could be seen. A lost or extra pending bit is visible on irq in the very next cycle, and it stays visible because the flag is held.

// File: rtl/irq_cnt_pkg.sv
// Shared definitions for the prescaled interrupt counter.
// Assumes the register window is eight byte-wide indices.
package irq_cnt_pkg;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        SRC_CPU_CYC = 2'd0,
        SRC_A12     = 2'd1,
        SRC_PPU_RD  = 2'd2,
        SRC_CPU_WR  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DIR_HOLD_LO = 2'd0,
        DIR_UP      = 2'd1,
        DIR_DOWN    = 2'd2,
        DIR_HOLD_HI = 2'd3
    } dir_e;

    // Register indices; their values are the software-visible map.
    localparam logic [IDX_W-1:0] IDX_ENSET = 3'd0;
    localparam logic [IDX_W-1:0] IDX_MODE  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_OFF   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ON    = 3'd3;
    localparam logic [IDX_W-1:0] IDX_PRE   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CNT   = 3'd5;
    localparam logic [IDX_W-1:0] IDX_KEY   = 3'd6;
    localparam logic [IDX_W-1:0] IDX_ADJ   = 3'd7;

    // Mode field positions.
    localparam int MODE_SRC_LSB = 0;
    localparam int MODE_NARROW  = 2;
    localparam int MODE_ADJ_EN  = 3;
    localparam int MODE_DIR_LSB = 6;
endpackage

// File: rtl/irq_cnt_regs.sv
// Register file: mode, XOR key, adjust mirror and enable, plus decoded
// load and acknowledge strobes. Assumes at most one write per clock.
module irq_cnt_regs
    import irq_cnt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] key_q,
    output logic [DATA_W-1:0] adj_q,
    output logic              en_q,
    output logic              pre_ld,
    output logic              cnt_ld,
    output logic [DATA_W-1:0] ld_val,
    output logic              ack
);
    logic hit_enset, hit_off, hit_on;

    // Purpose: decode write index into single-cycle strobes.
    always_comb begin
        hit_enset = wr_en && (wr_addr == IDX_ENSET);
        hit_off   = wr_en && (wr_addr == IDX_OFF);
        hit_on    = wr_en && (wr_addr == IDX_ON);
        pre_ld    = wr_en && (wr_addr == IDX_PRE);
        cnt_ld    = wr_en && (wr_addr == IDX_CNT);
        ld_val    = wr_data ^ key_q;
        ack       = hit_off || (hit_enset && !wr_data[0]);
    end

    // Purpose: hold the configuration bytes written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            key_q  <= '0;
            adj_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == IDX_MODE) mode_q <= wr_data;
            if (wr_addr == IDX_KEY)  key_q  <= wr_data;
            if (wr_addr == IDX_ADJ)  adj_q  <= wr_data;
        end
    end

    // Purpose: track the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (hit_enset) en_q <= wr_data[0];
        else if (hit_off)   en_q <= 1'b0;
        else if (hit_on)    en_q <= 1'b1;
    end
endmodule

// File: rtl/irq_cnt_prescaler.sv
// Event selection and prescaler. Emits a step toward the main counter
// when the masked prescaler rolls over. Assumes events are one-cycle pulses.
module irq_cnt_prescaler
    import irq_cnt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NARROW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        events,
    input  logic [DATA_W-1:0] mode,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] pre_q,
    output logic              step_up,
    output logic              step_dn
);
    localparam int NW = (NARROW_W < DATA_W) ? NARROW_W : DATA_W;

    dir_e              dir;
    src_e              src;
    logic              tick;
    logic [DATA_W-1:0] pre_nxt;
    logic [DATA_W-1:0] mask;

    // Purpose: pick the comparison mask from the width bit.
    generate
        if (NW < DATA_W) begin : g_narrow
            always_comb mask = mode[MODE_NARROW] ?
                {{(DATA_W-NW){1'b0}}, {NW{1'b1}}} : {DATA_W{1'b1}};
        end else begin : g_full
            always_comb mask = {DATA_W{1'b1}};
        end
    endgenerate

    // Purpose: qualify the selected event with an active direction.
    always_comb begin
        dir     = dir_e'(mode[MODE_DIR_LSB +: 2]);
        src     = src_e'(mode[MODE_SRC_LSB +: 2]);
        tick    = events[src] && (dir == DIR_UP || dir == DIR_DOWN);
        pre_nxt = (dir == DIR_UP) ? pre_q + 1'b1 : pre_q - 1'b1;
        step_up = tick && (dir == DIR_UP)   && ((pre_nxt & mask) == '0);
        step_dn = tick && (dir == DIR_DOWN) && ((pre_nxt & mask) == mask);
    end

    // Purpose: load or step the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (ld)   pre_q <= ld_val;
        else if (tick) pre_q <= pre_nxt;
    end
endmodule

// File: rtl/irq_cnt_main.sv
// Main counter. Steps on prescaler rollover and flags a wrap in the
// active direction. A load in the same cycle wins and hides the wrap.
module irq_cnt_main #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_dn,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic              wrap
);
    logic [DATA_W-1:0] cnt_nxt;

    // Purpose: next count and wrap detection.
    always_comb begin
        cnt_nxt = step_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        wrap    = !ld && ((step_up && cnt_nxt == '0) ||
                          (step_dn && cnt_nxt == '1));
    end

    // Purpose: load or step the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (ld)                cnt_q <= ld_val;
        else if (step_up || step_dn) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/irq_cnt_flag.sv
// Pending interrupt latch. Acknowledge wins over a coincident set.
module irq_cnt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend_q
);
    // Purpose: hold the level request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (clr) pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
    end
endmodule

// File: rtl/irq_prescale_counter.sv
// Top: prescaled 8-bit interrupt counter with four event sources, XOR-keyed
// loads and a read port. Assumes one-cycle event pulses on clk.
module irq_prescale_counter
    import irq_cnt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NARROW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              ev_cpu_cycle,
    input  logic              ev_a12_rise,
    input  logic              ev_ppu_read,
    input  logic              ev_cpu_write,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq
);
    logic [DATA_W-1:0] mode_q, key_q, adj_q, pre_q, cnt_q, ld_val;
    logic              en_q, pre_ld, cnt_ld, ack;
    logic              step_up, step_dn, wrap, pend_q;
    logic [3:0]        events;

    // Purpose: gather strobes in source-code order.
    always_comb events = {ev_cpu_write, ev_ppu_read, ev_a12_rise, ev_cpu_cycle};

    irq_cnt_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_q(mode_q), .key_q(key_q), .adj_q(adj_q),
        .en_q(en_q), .pre_ld(pre_ld), .cnt_ld(cnt_ld), .ld_val(ld_val),
        .ack(ack)
    );

    irq_cnt_prescaler #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .events(events), .mode(mode_q),
        .ld(pre_ld), .ld_val(ld_val), .pre_q(pre_q),
        .step_up(step_up), .step_dn(step_dn)
    );

    irq_cnt_main #(.DATA_W(DATA_W)) main_i (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
        .ld(cnt_ld), .ld_val(ld_val), .cnt_q(cnt_q), .wrap(wrap)
    );

    irq_cnt_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set(wrap && en_q), .clr(ack),
        .pend_q(pend_q)
    );

    // Purpose: read-port multiplexer and interrupt output.
    always_comb begin
        irq = pend_q;
        case (rd_addr)
            IDX_ENSET: rd_data = {7'd0, en_q};
            IDX_MODE:  rd_data = mode_q;
            IDX_OFF:   rd_data = {7'd0, pend_q};
            IDX_PRE:   rd_data = pre_q;
            IDX_CNT:   rd_data = cnt_q;
            IDX_KEY:   rd_data = key_q;
            IDX_ADJ:   rd_data = adj_q;
            default:   rd_data = 8'd0;
        endcase
    end
endmodule

// File: rtl/irq_cnt_checker.sv
// Temporal checks on the interrupt counter, bound into the top module.
module irq_cnt_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              irq,
    input logic              en_q,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] pre_q,
    input logic [DATA_W-1:0] key_q
);
    logic is_ack, stopped;
    always_comb begin
        is_ack  = wr_en && (wr_addr == 3'd2 || (wr_addr == 3'd0 && !wr_data[0]));
        stopped = (mode_q[7:6] == 2'b00) || (mode_q[7:6] == 2'b11);
    end

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack |=> !irq);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(en_q));

    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !is_ack) |=> irq);

    assert_stop_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !(wr_en && wr_addr == 3'd4)) |=> $stable(pre_q));

    assert_keyed_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4) |=> (pre_q == $past(wr_data ^ key_q)));
endmodule

bind irq_prescale_counter irq_cnt_checker #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .en_q(en_q), .mode_q(mode_q),
    .pre_q(pre_q), .key_q(key_q)
);

// File: tb/irq_prescale_counter_tb_top.sv
module irq_prescale_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] ev = 4'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq;

    int  n_chk = 0, n_fail = 0;
    bit  cmp_on = 0, done = 0;
    string cur_req = "R1";
    int  txor = 0;

    // behavioural reference state
    int m_pre, m_cnt, m_key, m_mode, m_adj, m_en, m_irq;
    int dir, src, msk, np, nc, tick, stp, wrp, ack;

    always #2.5 clk = ~clk;

    irq_prescale_counter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ev_cpu_cycle(ev[0]), .ev_a12_rise(ev[1]),
        .ev_ppu_read(ev[2]), .ev_cpu_write(ev[3]), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    always @(posedge clk) rd_addr <= rd_addr + 3'd1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_key = 0; m_mode = 0; m_adj = 0; m_en = 0; m_irq = 0;
        end else begin
            dir  = (m_mode >> 6) & 3;
            src  = m_mode & 3;
            msk  = (m_mode & 4) ? 7 : 255;
            tick = ev[src] && (dir == 1 || dir == 2);
            np   = (dir == 1) ? (m_pre + 1) & 255 : (m_pre + 255) & 255;
            stp  = tick && ((dir == 1) ? ((np & msk) == 0) : ((np & msk) == msk));
            nc   = (dir == 1) ? (m_cnt + 1) & 255 : (m_cnt + 255) & 255;
            wrp  = stp && !(wr_en && wr_addr == 5) && (nc == ((dir == 1) ? 0 : 255));
            ack  = wr_en && (wr_addr == 2 || (wr_addr == 0 && wr_data[0] == 0));
            if (ack) m_irq = 0; else if (wrp && m_en) m_irq = 1;
            if (wr_en && wr_addr == 4) m_pre = wr_data ^ m_key; else if (tick) m_pre = np;
            if (wr_en && wr_addr == 5) m_cnt = wr_data ^ m_key; else if (stp) m_cnt = nc;
            if (wr_en) begin
                case (wr_addr)
                    0: m_en = wr_data[0];
                    1: m_mode = wr_data;
                    2: m_en = 0;
                    3: m_en = 1;
                    6: m_key = wr_data;
                    7: m_adj = wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic int model_rd(input int a);
        case (a)
            0: return m_en;
            1: return m_mode;
            2: return m_irq;
            4: return m_pre;
            5: return m_cnt;
            6: return m_key;
            7: return m_adj;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) if (cmp_on) begin
        check({cur_req, " irq"}, irq, m_irq);
        check({cur_req, " rd_data"}, rd_data, model_rd(rd_addr));
    end

    task automatic wr(input int idx, input int data, input int evm = 0);
        wr_en = 1; wr_addr = idx[2:0]; wr_data = data[7:0]; ev = evm[3:0];
        @(posedge clk); #1;
        wr_en = 0; ev = 0;
    endtask

    task automatic pulse(input int evm, input int n = 1);
        for (int i = 0; i < n; i++) begin
            ev = evm[3:0]; @(posedge clk); #1; ev = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        cmp_on = 1;
        // R1: reset state
        check("R1 irq", irq, 0);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            check("R1 rd_data", rd_data, 0);
        end
        @(posedge clk); #1;

        // R7, R5, R2: keyed loads, count up on CPU cycles
        cur_req = "R7"; wr(6, 8'h5A); txor = 8'h5A;
        cur_req = "R5"; wr(1, 8'h40);
        wr(4, 8'hFE ^ txor); wr(5, 8'hFF ^ txor); wr(3, 0);
        cur_req = "R2"; pulse(4'b1110, 3);
        cur_req = "R5"; pulse(4'b0001, 2);
        check("R5 wrap up sets irq", irq, 1);
        cur_req = "R9"; idle(4);
        check("R9 irq held", irq, 1);
        cur_req = "R8"; wr(2, 0);
        check("R8 idx2 ack", irq, 0);

        // R6, R4: count down, narrow prescaler, A12 source
        cur_req = "R6"; wr(1, 8'h85);
        wr(4, 8'h00 ^ txor); wr(5, 8'h00 ^ txor); wr(3, 0);
        pulse(4'b0010);
        check("R6 wrap down sets irq", irq, 1);
        cur_req = "R8"; wr(0, 0);
        check("R8 idx0 bit0=0 ack", irq, 0);
        cur_req = "R4"; wr(1, 8'h81); wr(4, 8'h08 ^ txor);
        pulse(4'b0010, 20);
        wr(1, 8'h85); wr(4, 8'h08 ^ txor); pulse(4'b0010, 20);

        // R3: stopped directions
        cur_req = "R3"; wr(1, 8'h00); pulse(4'b1111, 6);
        wr(1, 8'hC2); pulse(4'b1111, 6);

        // R2: remaining sources
        cur_req = "R2"; wr(1, 8'h46); wr(3, 0); pulse(4'b0100, 30); pulse(4'b1011, 5);
        wr(1, 8'h47); pulse(4'b1000, 30); pulse(4'b0111, 5);

        // R9: wrap while disabled leaves irq low
        cur_req = "R9"; wr(2, 0); wr(0, 1); wr(0, 0);
        wr(1, 8'h44); wr(5, 8'hFF ^ txor); wr(4, 8'h07 ^ txor);
        pulse(4'b0001);
        check("R9 disabled wrap", irq, 0);

        // R10, R11: adjust register and mode bit 3
        cur_req = "R10"; wr(7, 8'hA5); wr(1, 8'h4C); wr(3, 0); pulse(4'b0001, 40);
        cur_req = "R11"; idle(16);

        // R12: load coincident with selected event
        cur_req = "R12"; wr(1, 8'h44); wr(5, 8'hFF ^ txor); wr(4, 8'h06 ^ txor);
        wr(5, 8'h10 ^ txor, 4'b0001);
        wr(4, 8'h33 ^ txor, 4'b0001);
        idle(8);

        // mixed stimulus
        cur_req = "R12 mixed";
        for (int c = 0; c < 4000; c++) begin
            int r = $urandom;
            ev = r[3:0];
            wr_en = (r[7:4] == 0);
            wr_addr = r[10:8];
            wr_data = r[18:11];
            @(posedge clk); #1;
            wr_en = 0; ev = 0;
        end
        idle(4);
        done = 1;
        report();
    end
endmodule